// File: doc/BRIEF.md
# Peripheral Access Filter with Compartment Check

This block decides, for each bus request aimed at one of a set of peripherals, whether the access may proceed. A request carries the target peripheral index, the requester's security state, its privilege level and a small compartment identifier. The block holds a configuration store for every peripheral. It holds a security bit and a privilege bit, packed 32 peripherals to a word. It also holds a per-peripheral compartment word, which has a filter-enable bit, a semaphore-mode bit, a static compartment field and a whitelist of compartments. An external semaphore bank supplies, for every peripheral, whether its semaphore is locked and which compartment holds it.

The checks form layers with a fixed order. First the index is checked against the number of implemented entries. The security bit comes next, then the privilege bit. Last comes either a match against the static compartment field or, in semaphore mode, whitelist membership together with current semaphore ownership. The result is registered: one cycle after a request, the block presents a grant flag and a three-bit reason code. The configuration store is written and read through a simple word-addressed port. A read-only word at the top of the map reports the three entry counts the instance was built with.

Top module: `pafw_filter`

## Requirements
- R1: The security bit of peripheral n is at address 0x10 + 4*(n/32), bit n%32; it reads back what was written, and bits for peripherals that do not exist read 0.
- R2: The privilege bit of peripheral n is at address 0x30 + 4*(n/32), bit n%32, with the same readback rule as R1.
- R3: The compartment word of peripheral n is at address 0x100 + 8*n: bit 0 filter enable, bit 1 semaphore mode, bits 6:4 static compartment, bits 23:16 whitelist (bit 16+c admits compartment c); all other bits read 0.
- R4: Address 0xFEC reads {CNT_C[7:0], CNT_B[7:0], CNT_A[15:0]} and ignores writes; the number of entries is CNT_A+CNT_B+CNT_C.
- R5: A request whose index is at or above the entry count is denied with reason 1.
- R6: A non-secure request (req_secure=0) to a peripheral whose security bit is 1 is denied with reason 2; secure requests pass this layer.
- R7: An unprivileged request (req_priv=0) to a peripheral whose privilege bit is 1 is denied with reason 3.
- R8: With filter enable 0, no compartment or semaphore check is made.
- R9: With filter enable 1 and semaphore mode 0, the request passes only if its compartment equals the static field or the static field is 0; otherwise reason 4.
- R10: With filter enable 1 and semaphore mode 1, the static field is ignored. A compartment outside the whitelist gets reason 4. A whitelisted one gets reason 5 unless the semaphore is locked and its owner equals the request's compartment.
- R11: Checks apply in the order index, security, privilege, compartment; the reason reported is the first failing layer.
- R12: rsp_valid is high exactly in the cycle after a cycle with req_valid high. With rsp_valid high, rsp_grant is 1 exactly when rsp_reason is 0. After reset, all configuration bits are 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational from cfg_addr |
| req_valid | input | 1 | Access request present |
| req_idx | input | IDX_W | Target peripheral index |
| req_secure | input | 1 | Requester is in secure state |
| req_priv | input | 1 | Requester is privileged |
| req_cid | input | 3 | Requester compartment identifier |
| sem_locked | input | NUM_P | Per-peripheral semaphore taken flag from the semaphore bank |
| sem_owner | input | 3*NUM_P | Per-peripheral semaphore owner compartment, peripheral n at bits 3n+2:3n |
| rsp_valid | output | 1 | Decision present, one cycle after the request |
| rsp_grant | output | 1 | Access granted |
| rsp_reason | output | 3 | 0 granted, 1 bad index, 2 security, 3 privilege, 4 compartment, 5 semaphore not held |

## Verification
The hardest outcome to produce from the ports is reason 5. It needs a valid index whose security and privilege layers pass, filter enable and semaphore mode both set, the requester present in the whitelist, and a semaphore that is free or held by another compartment. Random configuration rarely lines all of these up. Directed sequences therefore program one peripheral into semaphore mode with a chosen whitelist, then walk the semaphore inputs through free, held by the requester and held by a stranger. The random phase biases the security and privilege words toward zero and makes the semaphore owner often equal the requester, so the deeper layers are reached frequently.

// File: rtl/pafw_pkg.sv
package pafw_pkg;

    localparam int CID_W = 3;
    localparam int WL_W  = 1 << CID_W;

    // Per-peripheral compartment configuration
    typedef struct packed {
        logic [WL_W-1:0]  wl;       // whitelist, one bit per compartment
        logic [CID_W-1:0] scid;     // static compartment, 0 = any
        logic             sem_en;   // semaphore mode
        logic             flt_en;   // compartment filtering on
    } pcfg_t;

    typedef enum logic [2:0] {
        RSN_OK      = 3'd0,
        RSN_BAD_IDX = 3'd1,
        RSN_SECURE  = 3'd2,
        RSN_PRIV    = 3'd3,
        RSN_CID     = 3'd4,
        RSN_SEM     = 3'd5
    } reason_e;

    localparam logic [11:0] SEC_BASE = 12'h010;
    localparam logic [11:0] PRV_BASE = 12'h030;
    localparam logic [11:0] PC_BASE  = 12'h100;
    localparam logic [11:0] HW_ADDR  = 12'hFEC;

endpackage

// File: rtl/pafw_cfg_regs.sv
module pafw_cfg_regs
    import pafw_pkg::*;
#(
    parameter int CNT_A = 40,
    parameter int CNT_B = 6,
    parameter int CNT_C = 2,
    localparam int NUM_P = CNT_A + CNT_B + CNT_C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [11:0]         cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic [NUM_P-1:0]    sec_vec,
    output logic [NUM_P-1:0]    priv_vec,
    output pcfg_t [NUM_P-1:0]   pc_vec
);

    typedef struct packed {
        logic [NUM_P-1:0]  sec;
        logic [NUM_P-1:0]  priv;
        pcfg_t [NUM_P-1:0] pc;
    } regs_t;

    regs_t st_d, st_q;

    localparam logic [31:0] HW_WORD = {CNT_C[7:0], CNT_B[7:0], CNT_A[15:0]};

    // Next-state: decode writes
    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int n = 0; n < NUM_P; n++) begin
                if (cfg_addr == 12'(int'(SEC_BASE) + 4 * (n / 32)))
                    st_d.sec[n] = cfg_wdata[n % 32];
                if (cfg_addr == 12'(int'(PRV_BASE) + 4 * (n / 32)))
                    st_d.priv[n] = cfg_wdata[n % 32];
                if (cfg_addr == 12'(int'(PC_BASE) + 8 * n)) begin
                    st_d.pc[n].flt_en = cfg_wdata[0];
                    st_d.pc[n].sem_en = cfg_wdata[1];
                    st_d.pc[n].scid   = cfg_wdata[4 +: CID_W];
                    st_d.pc[n].wl     = cfg_wdata[16 +: WL_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux
    always_comb begin
        cfg_rdata = '0;
        for (int n = 0; n < NUM_P; n++) begin
            if (cfg_addr == 12'(int'(SEC_BASE) + 4 * (n / 32)))
                cfg_rdata[n % 32] = st_q.sec[n];
            if (cfg_addr == 12'(int'(PRV_BASE) + 4 * (n / 32)))
                cfg_rdata[n % 32] = st_q.priv[n];
            if (cfg_addr == 12'(int'(PC_BASE) + 8 * n)) begin
                cfg_rdata[0]            = st_q.pc[n].flt_en;
                cfg_rdata[1]            = st_q.pc[n].sem_en;
                cfg_rdata[4 +: CID_W]   = st_q.pc[n].scid;
                cfg_rdata[16 +: WL_W]   = st_q.pc[n].wl;
            end
        end
        if (cfg_addr == HW_ADDR) cfg_rdata = HW_WORD;
    end

    assign sec_vec  = st_q.sec;
    assign priv_vec = st_q.priv;
    assign pc_vec   = st_q.pc;

endmodule

// File: rtl/pafw_decide.sv
module pafw_decide
    import pafw_pkg::*;
(
    input  logic             in_range,
    input  logic             sec_bit,
    input  logic             priv_bit,
    input  pcfg_t            pcfg,
    input  logic             lock_bit,
    input  logic [CID_W-1:0] owner,
    input  logic             req_secure,
    input  logic             req_priv,
    input  logic [CID_W-1:0] req_cid,
    output reason_e          reason,
    output logic             grant
);

    logic sec_ok, priv_ok, wl_hit, own_hit, static_ok, cid_ok;

    always_comb begin
        sec_ok    = req_secure | ~sec_bit;
        priv_ok   = req_priv | ~priv_bit;
        wl_hit    = pcfg.wl[req_cid];
        own_hit   = lock_bit & (owner == req_cid);
        static_ok = (pcfg.scid == '0) | (pcfg.scid == req_cid);
        if (!pcfg.flt_en)     cid_ok = 1'b1;
        else if (pcfg.sem_en) cid_ok = wl_hit & own_hit;
        else                  cid_ok = static_ok;

        grant = in_range & sec_ok & priv_ok & cid_ok;

        // Layered reason, first failing layer wins
        if (!in_range)                          reason = RSN_BAD_IDX;
        else if (!sec_ok)                       reason = RSN_SECURE;
        else if (!priv_ok)                      reason = RSN_PRIV;
        else if (!pcfg.flt_en)                  reason = RSN_OK;
        else if (pcfg.sem_en && !wl_hit)        reason = RSN_CID;
        else if (pcfg.sem_en && !own_hit)       reason = RSN_SEM;
        else if (!pcfg.sem_en && !static_ok)    reason = RSN_CID;
        else                                    reason = RSN_OK;
    end

endmodule

// File: rtl/pafw_filter.sv
module pafw_filter
    import pafw_pkg::*;
#(
    parameter int CNT_A = 40,
    parameter int CNT_B = 6,
    parameter int CNT_C = 2,
    parameter int IDX_W = 6,
    localparam int NUM_P = CNT_A + CNT_B + CNT_C
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [11:0]             cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    input  logic                    req_valid,
    input  logic [IDX_W-1:0]        req_idx,
    input  logic                    req_secure,
    input  logic                    req_priv,
    input  logic [2:0]              req_cid,
    input  logic [NUM_P-1:0]        sem_locked,
    input  logic [3*NUM_P-1:0]      sem_owner,
    output logic                    rsp_valid,
    output logic                    rsp_grant,
    output logic [2:0]              rsp_reason
);

    typedef struct packed {
        logic    valid;
        logic    grant;
        reason_e reason;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [NUM_P-1:0]  sec_vec, priv_vec;
    pcfg_t [NUM_P-1:0] pc_vec;

    logic             in_range, sel_sec, sel_priv, sel_lock;
    pcfg_t            sel_pc;
    logic [CID_W-1:0] sel_owner;
    reason_e          dec_reason;
    logic             dec_grant;

    pafw_cfg_regs #(.CNT_A(CNT_A), .CNT_B(CNT_B), .CNT_C(CNT_C)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sec_vec   (sec_vec),
        .priv_vec  (priv_vec),
        .pc_vec    (pc_vec)
    );

    // Entry select; out-of-range leaves everything zero
    always_comb begin
        in_range  = 1'b0;
        sel_sec   = 1'b0;
        sel_priv  = 1'b0;
        sel_lock  = 1'b0;
        sel_pc    = '0;
        sel_owner = '0;
        for (int n = 0; n < NUM_P; n++) begin
            if (req_idx == IDX_W'(n)) begin
                in_range  = 1'b1;
                sel_sec   = sec_vec[n];
                sel_priv  = priv_vec[n];
                sel_lock  = sem_locked[n];
                sel_pc    = pc_vec[n];
                sel_owner = sem_owner[n*CID_W +: CID_W];
            end
        end
    end

    pafw_decide u_dec (
        .in_range   (in_range),
        .sec_bit    (sel_sec),
        .priv_bit   (sel_priv),
        .pcfg       (sel_pc),
        .lock_bit   (sel_lock),
        .owner      (sel_owner),
        .req_secure (req_secure),
        .req_priv   (req_priv),
        .req_cid    (req_cid),
        .reason     (dec_reason),
        .grant      (dec_grant)
    );

    always_comb begin
        rsp_d        = '0;
        rsp_d.valid  = req_valid;
        if (req_valid) begin
            rsp_d.grant  = dec_grant;
            rsp_d.reason = dec_reason;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_grant  = rsp_q.grant;
    assign rsp_reason = rsp_q.reason;

endmodule

// File: rtl/pafw_filter_chk.sv
module pafw_filter_chk
    import pafw_pkg::*;
#(
    parameter int NUM_P = 48,
    parameter int IDX_W = 6,
    parameter logic [31:0] HW_WORD = 32'h0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [11:0]      cfg_addr,
    input logic [31:0]      cfg_rdata,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic             req_secure,
    input logic             req_priv,
    input logic [2:0]       req_cid,
    input logic             sel_sec,
    input logic             sel_priv,
    input logic             sel_lock,
    input logic [2:0]       sel_owner,
    input pcfg_t            sel_pc,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic [2:0]       rsp_reason
);

    logic idx_ok, layers_ok;
    assign idx_ok    = (int'(req_idx) < NUM_P);
    assign layers_ok = idx_ok && (req_secure || !sel_sec) && (req_priv || !sel_priv);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                               // R12
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);                                             // R12
    AST_GRANT_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant == (rsp_reason == 3'd0)));                     // R12
    AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !idx_ok) |=> (rsp_reason == 3'd1 && !rsp_grant));        // R5
    AST_SECURE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idx_ok && !req_secure && sel_sec) |=> (rsp_reason == 3'd2)); // R6
    AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idx_ok && (req_secure || !sel_sec) && !req_priv && sel_priv)
        |=> (rsp_reason == 3'd3));                                              // R7
    AST_FILTER_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && layers_ok && !sel_pc.flt_en) |=> rsp_grant);              // R8
    AST_SEM_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && layers_ok && sel_pc.flt_en && sel_pc.sem_en && sel_pc.wl[req_cid]
         && !(sel_lock && sel_owner == req_cid)) |=> (rsp_reason == 3'd5));      // R10
    AST_HW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == HW_ADDR) |-> (cfg_rdata == HW_WORD));                      // R4

endmodule

bind pafw_filter pafw_filter_chk #(
    .NUM_P   (NUM_P),
    .IDX_W   (IDX_W),
    .HW_WORD ({CNT_C[7:0], CNT_B[7:0], CNT_A[15:0]})
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .req_secure (req_secure),
    .req_priv   (req_priv),
    .req_cid    (req_cid),
    .sel_sec    (sel_sec),
    .sel_priv   (sel_priv),
    .sel_lock   (sel_lock),
    .sel_owner  (sel_owner),
    .sel_pc     (sel_pc),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_reason (rsp_reason)
);

// File: tb/test_pafw_filter.sv
`timescale 1ns/1ps
module test_pafw_filter;

    localparam int CA = 40, CB = 6, CC = 2;
    localparam int NP = CA + CB + CC;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic req_valid = 1'b0;
    logic [IW-1:0] req_idx = '0;
    logic req_secure = 1'b0, req_priv = 1'b0;
    logic [2:0] req_cid = '0;
    logic [NP-1:0] sem_locked = '0;
    logic [3*NP-1:0] sem_owner = '0;
    logic rsp_valid, rsp_grant;
    logic [2:0] rsp_reason;

    int n_chk = 0, n_bad = 0;

    // Bench model of configuration
    logic m_sec [NP], m_prv [NP], m_fe [NP], m_se [NP];
    logic [2:0] m_sc [NP];
    logic [7:0] m_wl [NP];

    always #10 clk = ~clk;

    pafw_filter #(.CNT_A(CA), .CNT_B(CB), .CNT_C(CC), .IDX_W(IW)) i_pafw_filter (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_reason(int idx, logic s, logic p, logic [2:0] c);
        logic own;
        if (idx >= NP) return 3'd1;
        if (m_sec[idx] && !s) return 3'd2;
        if (m_prv[idx] && !p) return 3'd3;
        if (!m_fe[idx]) return 3'd0;
        if (m_se[idx]) begin
            own = sem_locked[idx] && (sem_owner[idx*3 +: 3] == c);
            if (!m_wl[idx][c]) return 3'd4;
            return own ? 3'd0 : 3'd5;
        end
        if (m_sc[idx] != 3'd0 && m_sc[idx] != c) return 3'd4;
        return 3'd0;
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic set_pc(int n, logic fe, logic se, logic [2:0] sc, logic [7:0] wl);
        m_fe[n] = fe; m_se[n] = se; m_sc[n] = sc; m_wl[n] = wl;
        wr(12'(12'h100 + 8 * n), {8'h0, wl, 9'h0, sc, 2'b0, se, fe});
    endtask

    task automatic set_word(bit prv, int w, logic [31:0] d);
        for (int b = 0; b < 32; b++)
            if (w * 32 + b < NP) begin
                if (prv) m_prv[w*32+b] = d[b];
                else     m_sec[w*32+b] = d[b];
            end
        wr(12'((prv ? 12'h30 : 12'h10) + 4 * w), d);
    endtask

    task automatic req(int idx, logic s, logic p, logic [2:0] c, string tag);
        logic [2:0] e;
        e = exp_reason(idx, s, p, c);
        @(negedge clk);
        req_valid = 1'b1; req_idx = IW'(idx); req_secure = s; req_priv = p; req_cid = c;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " reason"}, 32'(rsp_reason), 32'(e));
        chk({tag, " grant (R12)"}, 32'(rsp_grant), 32'(e == 3'd0));
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int n = 0; n < NP; n++) begin
            m_sec[n] = 0; m_prv[n] = 0; m_fe[n] = 0; m_se[n] = 0; m_sc[n] = 0; m_wl[n] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R12 reset rsp_valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        rd(12'h010, 32'h0, "R12 reset sec word");
        rd(12'h034, 32'h0, "R12 reset priv word");
        rd(12'h100 + 12'(8 * 47), 32'h0, "R12 reset pc word");
        @(negedge clk);
        #1 chk("R12 no response without request", 32'(rsp_valid), 32'd0);

        // R1 / R2 packing and readback
        set_word(0, 1, 32'hFFFF_FFFF);
        rd(12'h014, 32'h0000_FFFF, "R1 sec word1 upper bits read 0");
        set_word(0, 1, 32'h0000_8001);
        rd(12'h014, 32'h0000_8001, "R1 sec word1 readback");
        set_word(1, 0, 32'h8000_0004);
        rd(12'h030, 32'h8000_0004, "R2 priv word0 readback");
        rd(12'h010, 32'h0, "R1 sec word0 untouched");
        // R3 field positions, other bits dropped
        wr(12'h100 + 12'(8 * 5), 32'hFFFF_FFFF);
        m_fe[5] = 1; m_se[5] = 1; m_sc[5] = 3'd7; m_wl[5] = 8'hFF;
        rd(12'h100 + 12'(8 * 5), 32'h00FF_0073, "R3 pc word field mask");
        // R4 hardware word
        rd(12'hFEC, {8'(CC), 8'(CB), 16'(CA)}, "R4 hw word");
        wr(12'hFEC, 32'h1234_5678);
        rd(12'hFEC, {8'(CC), 8'(CB), 16'(CA)}, "R4 hw word write ignored");

        // R5 index boundary
        req(NP - 1, 1, 1, 3'd0, "R5 last valid index");
        req(NP, 1, 1, 3'd0, "R5 first invalid index");
        req(63, 1, 1, 3'd0, "R5 top index");

        // R6 / R7 / R11: peripheral 32 secure (word1 bit0), peripheral 2 privileged
        req(32, 0, 1, 3'd1, "R6 nonsecure to secure");
        req(32, 1, 1, 3'd1, "R6 secure to secure");
        req(2, 1, 0, 3'd1, "R7 unprivileged to privileged");
        set_word(1, 1, 32'h0000_0001);
        set_pc(32, 1, 0, 3'd3, 8'h0);
        req(32, 0, 0, 3'd1, "R11 security before privilege");
        req(32, 1, 0, 3'd1, "R11 privilege before compartment");
        req(32, 1, 1, 3'd1, "R11 compartment last");

        // R8 / R9 static compartment
        set_pc(10, 0, 0, 3'd3, 8'h0);
        req(10, 1, 1, 3'd5, "R8 filter off any cid");
        set_pc(10, 1, 0, 3'd3, 8'h0);
        req(10, 1, 1, 3'd3, "R9 static match");
        req(10, 1, 1, 3'd4, "R9 static mismatch");
        set_pc(10, 1, 0, 3'd0, 8'h0);
        req(10, 0, 0, 3'd6, "R9 static zero accepts any");

        // R10 semaphore mode: static field 2 must be ignored
        set_pc(11, 1, 1, 3'd2, 8'b0001_0010);
        sem_locked[11] = 1'b0;
        req(11, 1, 1, 3'd2, "R10 not whitelisted");
        req(11, 1, 1, 3'd4, "R10 whitelisted sem free");
        sem_locked[11] = 1'b1; sem_owner[33 +: 3] = 3'd1;
        req(11, 1, 1, 3'd4, "R10 held by other");
        sem_owner[33 +: 3] = 3'd4;
        req(11, 1, 1, 3'd4, "R10 held by requester");
        set_pc(11, 0, 1, 3'd2, 8'h00);
        req(11, 1, 1, 3'd7, "R8 sem bit with filter off");

        // Random phase
        for (int round = 0; round < 6; round++) begin
            for (int w = 0; w < 2; w++) begin
                set_word(0, w, $urandom & $urandom & $urandom);
                set_word(1, w, $urandom & $urandom & $urandom);
            end
            for (int n = 0; n < NP; n++) begin
                logic [31:0] r;
                r = $urandom;
                set_pc(n, r[0], r[1], r[6:4], r[23:16]);
            end
            for (int k = 0; k < 60; k++) begin
                logic [2:0] c;
                int idx;
                c = 3'($urandom_range(0, 7));
                idx = ($urandom_range(0, 9) == 0) ? $urandom_range(NP, 63) : $urandom_range(0, NP - 1);
                if (idx < NP) begin
                    sem_locked[idx] = ($urandom_range(0, 3) != 0);
                    sem_owner[idx*3 +: 3] = ($urandom_range(0, 1) == 1) ? c : 3'($urandom);
                end
                req(idx, 1'($urandom), 1'($urandom), c, "R11 random layered decision");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule